// File: doc/BRIEF.md
# RS-485 Command Frame Receiver

This block listens on the receive wire of a half-duplex RS-485 transceiver and turns the serial characters into fixed-length command packets for the controller of a trigger board. A two-flop synchronizer feeds an oversampling receiver. The receiver centres on each bit and checks both stop bits. A packet assembler waits for the delimiter byte, collects the rest of the packet, and accepts it only when two tests pass: the destination byte must name this board, and the trailing checksum must agree with the sum of the bytes before it.

A packet has sixteen bytes, and the gaps between them may differ widely. When a packet is accepted, the instruction byte and the eleven payload bytes appear on registered outputs. A strobe lasting one clock marks each acceptance. A packet that is rejected leaves no trace at the outputs. The block also holds the transceiver in listen mode, with its receiver enabled and its driver disabled.

Top module: `rs485_cmd_rx`

## Requirements
- R1: While reset is asserted and afterwards, `frame_stb` is 0, `xcvr_rx_en` is 1 and `xcvr_tx_en` is 0. After reset, `cmd_instr` and `cmd_payload` are all zero.
- R2: A character on the idle-high line is one low start bit, then eight data bits sent least significant first, then two high stop bits. Each bit lasts `CLKS_PER_BIT` clocks, and each bit is sampled near its centre.
- R3: A low pulse shorter than half a bit period is rejected as a false start and produces no byte.
- R4: While no packet is open, every byte other than the delimiter 0x40 is discarded. A delimiter opens a packet.
- R5: Byte positions are fixed: 0 is the delimiter, 1 the destination, 2 the source, 3 the instruction, 4 to 14 the payload, and 15 the checksum. `cmd_instr` takes byte 3. `cmd_payload[8k+7:8k]` takes payload byte k, where k = 0 is byte 4.
- R6: A packet is accepted only when byte 1 equals `board_addr` zero-extended to 8 bits. Any other value drops the packet, including values where only the upper two bits differ.
- R7: A packet is accepted only when byte 15 equals the modulo-256 sum of bytes 0 to 14. Any other value drops it.
- R8: `frame_stb` is high for exactly one clock per accepted packet. `cmd_instr` and `cmd_payload` change only in the cycle of that strobe and otherwise hold their values.
- R9: Gaps of idle line between consecutive bytes of a packet, from none up to just below the timeout, do not disturb assembly.
- R10: If more than `TIMEOUT_CLKS` clocks pass between the completions of consecutive bytes of an open packet, the packet is discarded and the block returns to waiting for a delimiter.
- R11: A low sample at either stop-bit position discards the byte, abandons the open packet, and the receiver waits for the line to go high before it looks for the next start bit.
- R12: A 0x40 byte inside an open packet is handled as ordinary packet content and does not restart the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Serial receive wire from the transceiver, asynchronous, idle high |
| board_addr | input | ADDR_W | Geographic board address |
| xcvr_rx_en | output | 1 | Transceiver receiver enable, active high |
| xcvr_tx_en | output | 1 | Transceiver driver enable, active high |
| frame_stb | output | 1 | One-clock strobe for an accepted packet |
| cmd_instr | output | 8 | Instruction byte of the last accepted packet |
| cmd_payload | output | 8*DATA_BYTES | Payload bytes of the last accepted packet, first byte in the low bits |

## Verification
The character receiver's error detection and the assembler's completion of a packet can land on the same byte. This happens when the checksum byte itself carries a low stop bit. In that case the error must win, and no strobe may appear even though every byte of the packet and the checksum are otherwise correct. The bench provokes this by sending a fully valid packet whose final character has a low first stop bit. It judges the result at the ports: the strobe count must not rise, the outputs must still hold the previous packet, and a clean packet sent right after must be accepted.

// File: rtl/rs485_rx_pkg.sv
package rs485_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP1,
    RX_STOP2,
    RX_RECOVER
  } rx_state_t;

  typedef enum logic {
    FA_HUNT,
    FA_COLLECT
  } fa_state_t;

  // delimiter, destination, source, instruction
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned POS_DEST  = 1;
  localparam int unsigned POS_INSTR = 3;

endpackage

// File: rtl/rs485_line_sync.sv
module rs485_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 1'b1;
          else     pipe[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 1'b1;
          else     pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/rs485_uart_rx.sv
module rs485_uart_rx
  import rs485_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_s,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       byte_err
);

  localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT);
  localparam int unsigned HALF  = CLKS_PER_BIT / 2;
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(HALF - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      byte_err   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      byte_err   <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!rx_s) state <= RX_START;
        end
        RX_START: begin
          if (cnt == HALF_M1) begin
            cnt     <= '0;
            bit_idx <= '0;
            // a start bit that is high again at its centre is noise
            state   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == FULL_M1) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[7:1]};
            if (bit_idx == 3'd7) state <= RX_STOP1;
            else                 bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP1: begin
          if (cnt == FULL_M1) begin
            cnt <= '0;
            if (!rx_s) begin
              byte_err <= 1'b1;
              state    <= RX_RECOVER;
            end else begin
              state <= RX_STOP2;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP2: begin
          if (cnt == FULL_M1) begin
            cnt <= '0;
            if (!rx_s) begin
              byte_err <= 1'b1;
              state    <= RX_RECOVER;
            end else begin
              byte_valid <= 1'b1;
              byte_data  <= shreg;
              state      <= RX_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_RECOVER: begin
          cnt <= '0;
          if (rx_s) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R11
  no_dual_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid && byte_err));

  // R2
  stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(rx_s));

  // R11
  err_low_chk: assert property (@(posedge clk) disable iff (rst)
    byte_err |-> !$past(rx_s));

endmodule

// File: rtl/rs485_frame_asm.sv
module rs485_frame_asm
  import rs485_rx_pkg::*;
#(
  parameter int unsigned DATA_BYTES   = 11,
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned TIMEOUT_CLKS = 50000,
  parameter logic [7:0]  DELIM_BYTE   = 8'h40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              byte_data,
  input  logic                    byte_valid,
  input  logic                    byte_err,
  input  logic [ADDR_W-1:0]       board_addr,
  output logic                    frame_stb,
  output logic [7:0]              cmd_instr,
  output logic [8*DATA_BYTES-1:0] cmd_payload
);

  localparam int unsigned FRAME_BYTES = HDR_BYTES + DATA_BYTES + 1;
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES);
  localparam int unsigned DATA_W      = 8 * DATA_BYTES;
  localparam int unsigned TMO_W       = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_DEST  = IDX_W'(POS_DEST);
  localparam logic [IDX_W-1:0] IDX_INSTR = IDX_W'(POS_INSTR);
  localparam logic [TMO_W-1:0] TMO_M1    = TMO_W'(TIMEOUT_CLKS - 1);

  fa_state_t         state;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        sum;
  logic [7:0]        dest_q;
  logic [7:0]        instr_q;
  logic [DATA_W-1:0] data_sr;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [7:0]        own_addr;
  logic              is_payload;

  assign own_addr   = {{(8 - ADDR_W){1'b0}}, board_addr};
  assign is_payload = (idx > IDX_INSTR) && (idx < IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= FA_HUNT;
      idx         <= '0;
      sum         <= '0;
      dest_q      <= '0;
      instr_q     <= '0;
      data_sr     <= '0;
      tmo_cnt     <= '0;
      frame_stb   <= 1'b0;
      cmd_instr   <= '0;
      cmd_payload <= '0;
    end else begin
      frame_stb <= 1'b0;
      case (state)
        FA_HUNT: begin
          tmo_cnt <= '0;
          if (byte_valid && byte_data == DELIM_BYTE) begin
            state <= FA_COLLECT;
            idx   <= IDX_W'(1);
            sum   <= byte_data;
          end
        end
        FA_COLLECT: begin
          if (byte_err) begin
            state <= FA_HUNT;
          end else if (byte_valid) begin
            tmo_cnt <= '0;
            idx     <= idx + 1'b1;
            sum     <= sum + byte_data;
            if (idx == IDX_DEST)  dest_q  <= byte_data;
            if (idx == IDX_INSTR) instr_q <= byte_data;
            if (is_payload) data_sr <= {byte_data, data_sr[DATA_W-1:8]};
            if (idx == IDX_LAST) begin
              state <= FA_HUNT;
              if (sum == byte_data && dest_q == own_addr) begin
                frame_stb   <= 1'b1;
                cmd_instr   <= instr_q;
                cmd_payload <= data_sr;
              end
            end
          end else if (tmo_cnt == TMO_M1) begin
            state <= FA_HUNT;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        default: state <= FA_HUNT;
      endcase
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> !frame_stb);

  // R8
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |-> ($stable(cmd_instr) && $stable(cmd_payload)));

  // R5
  stb_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> $past(byte_valid && state == FA_COLLECT));

  // R10
  tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_cnt < TMO_W'(TIMEOUT_CLKS));

  // R4
  hunt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == FA_HUNT && !(byte_valid && byte_data == DELIM_BYTE)) |=> state == FA_HUNT);

endmodule

// File: rtl/rs485_cmd_rx.sv
module rs485_cmd_rx #(
  parameter int unsigned CLKS_PER_BIT = 500,
  parameter int unsigned DATA_BYTES   = 11,
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned TIMEOUT_CLKS = 50000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_line,
  input  logic [ADDR_W-1:0]       board_addr,
  output logic                    xcvr_rx_en,
  output logic                    xcvr_tx_en,
  output logic                    frame_stb,
  output logic [7:0]              cmd_instr,
  output logic [8*DATA_BYTES-1:0] cmd_payload
);

  logic       rx_s;
  logic [7:0] byte_data;
  logic       byte_valid;
  logic       byte_err;

  rs485_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (rx_s)
  );

  rs485_uart_rx #(
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) u_uart (
    .clk        (clk),
    .rst        (rst),
    .rx_s       (rx_s),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_err   (byte_err)
  );

  rs485_frame_asm #(
    .DATA_BYTES   (DATA_BYTES),
    .ADDR_W       (ADDR_W),
    .TIMEOUT_CLKS (TIMEOUT_CLKS),
    .DELIM_BYTE   (8'h40)
  ) u_asm (
    .clk         (clk),
    .rst         (rst),
    .byte_data   (byte_data),
    .byte_valid  (byte_valid),
    .byte_err    (byte_err),
    .board_addr  (board_addr),
    .frame_stb   (frame_stb),
    .cmd_instr   (cmd_instr),
    .cmd_payload (cmd_payload)
  );

  // listen-only: receiver on, driver off
  always_ff @(posedge clk) begin
    if (rst) begin
      xcvr_rx_en <= 1'b1;
      xcvr_tx_en <= 1'b0;
    end else begin
      xcvr_rx_en <= 1'b1;
      xcvr_tx_en <= 1'b0;
    end
  end

  // R1
  listen_mode_chk: assert property (@(posedge clk) disable iff (rst)
    xcvr_rx_en && !xcvr_tx_en);

endmodule

// File: tb/rs485_cmd_rx_tb.sv
module rs485_cmd_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 16;
  localparam int NDATA      = 11;
  localparam int TMO        = 1000;
  localparam int AW         = 6;
  localparam int NBYTES     = NDATA + 5;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               rx_line = 1'b1;
  logic [AW-1:0]      board_addr = '0;
  logic               xcvr_rx_en, xcvr_tx_en, frame_stb;
  logic [7:0]         cmd_instr;
  logic [8*NDATA-1:0] cmd_payload;

  int n_checks = 0;
  int n_err    = 0;
  int stb_cnt  = 0;
  int base_cnt = 0;
  logic [7:0]         cap_instr = '0;
  logic [8*NDATA-1:0] cap_payload = '0;
  logic [7:0]         good_instr = '0;
  logic [8*NDATA-1:0] good_payload = '0;

  logic [7:0] fr [NBYTES];
  int         gaps [NBYTES];

  rs485_cmd_rx #(
    .CLKS_PER_BIT (CPB),
    .DATA_BYTES   (NDATA),
    .ADDR_W       (AW),
    .TIMEOUT_CLKS (TMO),
    .SYNC_STAGES  (2)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .rx_line     (rx_line),
    .board_addr  (board_addr),
    .xcvr_rx_en  (xcvr_rx_en),
    .xcvr_tx_en  (xcvr_tx_en),
    .frame_stb   (frame_stb),
    .cmd_instr   (cmd_instr),
    .cmd_payload (cmd_payload)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && frame_stb) begin
      stb_cnt     <= stb_cnt + 1;
      cap_instr   <= cmd_instr;
      cap_payload <= cmd_payload;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] csum();
    logic [7:0] s = '0;
    for (int i = 0; i < NBYTES - 1; i++) s = s + fr[i];
    return s;
  endfunction

  task automatic build(input logic [7:0] dest, input logic [7:0] instr, input bit rnd);
    fr[0] = 8'h40;
    fr[1] = dest;
    fr[2] = 8'h03;
    fr[3] = instr;
    for (int k = 0; k < NDATA; k++) fr[4+k] = rnd ? 8'($urandom) : 8'(k + 1);
    fr[NBYTES-1] = csum();
    for (int i = 0; i < NBYTES; i++) gaps[i] = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit bad_stop, input int gap);
    @(negedge clk) rx_line = 1'b0;
    repeat (CPB - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rx_line = b[i];
      repeat (CPB - 1) @(negedge clk);
    end
    @(negedge clk) rx_line = bad_stop ? 1'b0 : 1'b1;
    repeat (CPB - 1) @(negedge clk);
    @(negedge clk) rx_line = 1'b1;
    repeat (CPB - 1 + gap) @(negedge clk);
  endtask

  task automatic send_frame(input int bad_idx);
    for (int i = 0; i < NBYTES; i++) send_byte(fr[i], (i == bad_idx), gaps[i]);
  endtask

  task automatic expect_result(input bit accept, input string tag);
    logic [8*NDATA-1:0] exp_pl;
    repeat (30) @(negedge clk);
    for (int k = 0; k < NDATA; k++) exp_pl[8*k +: 8] = fr[4+k];
    chk({tag, " strobe count"}, 128'(stb_cnt - base_cnt), 128'(accept));
    if (accept) begin
      chk({tag, " instr"}, 128'(cap_instr), 128'(fr[3]));
      chk({tag, " payload"}, 128'(cap_payload), 128'(exp_pl));
      good_instr   = fr[3];
      good_payload = exp_pl;
    end else begin
      chk({tag, " R8 instr held"}, 128'(cmd_instr), 128'(good_instr));
      chk({tag, " R8 payload held"}, 128'(cmd_payload), 128'(good_payload));
    end
    base_cnt = stb_cnt;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0815));
    board_addr = 6'd5;
    repeat (5) @(negedge clk);
    chk("R1 strobe in reset", 128'(frame_stb), 128'(0));
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rx_en", 128'(xcvr_rx_en), 128'(1));
    chk("R1 tx_en", 128'(xcvr_tx_en), 128'(0));
    chk("R1 instr reset", 128'(cmd_instr), 128'(0));
    chk("R1 payload reset", 128'(cmd_payload), 128'(0));

    // R2 R5: back-to-back bytes
    build(8'd5, 8'hA7, 1'b0);
    send_frame(-1);
    expect_result(1'b1, "R2 R5 basic");

    // R4: noise before delimiter
    send_byte(8'h41, 1'b0, 3);
    send_byte(8'h00, 1'b0, 0);
    send_byte(8'hC0, 1'b0, 7);
    build(8'd5, 8'h3C, 1'b1);
    send_frame(-1);
    expect_result(1'b1, "R4 hunt");

    // R3: short low glitch
    @(negedge clk) rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 no strobe from glitch", 128'(stb_cnt - base_cnt), 128'(0));
    build(8'd5, 8'h19, 1'b1);
    send_frame(-1);
    expect_result(1'b1, "R3 after glitch");

    // R6: wrong destination, and upper-bit mismatch
    build(8'd6, 8'h77, 1'b1);
    send_frame(-1);
    expect_result(1'b0, "R6 wrong dest");
    build(8'h45, 8'h78, 1'b1);
    send_frame(-1);
    expect_result(1'b0, "R6 upper bits");

    // R7: bad checksum
    build(8'd5, 8'h55, 1'b1);
    fr[NBYTES-1] = fr[NBYTES-1] ^ 8'h10;
    send_frame(-1);
    expect_result(1'b0, "R7 checksum");

    // R11: stop-bit error mid frame, then recovery
    build(8'd5, 8'h66, 1'b1);
    send_frame(7);
    expect_result(1'b0, "R11 framing");
    build(8'd5, 8'h67, 1'b1);
    send_frame(-1);
    expect_result(1'b1, "R11 recovery");

    // R11: error on the checksum byte of a valid frame (coincidence)
    build(8'd5, 8'h68, 1'b1);
    send_frame(NBYTES - 1);
    expect_result(1'b0, "R11 bad stop on checksum");
    build(8'd5, 8'h69, 1'b1);
    send_frame(-1);
    expect_result(1'b1, "R11 clean after coincidence");

    // R10: gap beyond timeout; trailing bytes contain no 0x40
    build(8'd5, 8'h22, 1'b0);
    for (int k = 0; k < NDATA; k++) fr[4+k] = 8'h01;
    fr[NBYTES-1] = csum();
    gaps[5] = 2000;
    send_frame(-1);
    expect_result(1'b0, "R10 timeout");

    // R9: long gaps below timeout
    build(8'd5, 8'h23, 1'b1);
    gaps[2] = 700;
    gaps[9] = 600;
    send_frame(-1);
    expect_result(1'b1, "R9 long gaps");

    // R12: delimiter values inside the frame
    build(8'd5, 8'h40, 1'b1);
    fr[4] = 8'h40; fr[10] = 8'h40; fr[2] = 8'h40;
    fr[NBYTES-1] = csum();
    send_frame(-1);
    expect_result(1'b1, "R12 embedded delimiter");

    // random frames
    for (int n = 0; n < 12; n++) begin
      bit match;
      logic [AW-1:0] a;
      a = AW'($urandom);
      board_addr = a;
      match = ($urandom % 5) != 0;
      build(match ? {2'b00, a} : {2'b00, a ^ AW'(1 + $urandom % 63)}, 8'($urandom), 1'b1);
      for (int i = 0; i < NBYTES; i++) gaps[i] = $urandom % 150;
      send_frame(-1);
      expect_result(match, match ? "R5 R9 random accept" : "R6 random reject");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule